// File: doc/BRIEF.md
# Management-Bus PHY Register Emulator

This block stands in for a simple Ethernet PHY on a two-wire management bus. It samples the management clock and data line with the system clock. On each rising edge of the management clock it decodes clause-22 style frames: a run of ones, a start pattern, a two-bit opcode, a five-bit PHY address, a five-bit register number, a two-bit turnaround and sixteen data bits.

A frame acts only when its PHY address equals the strap address on `phy_addr`. Writes then update a bank of thirty-two 16-bit registers. Reads are answered by driving the data line during the second turnaround bit and the data phase. Several registers are not stored. The status, partner-ability and diagnostic words are computed when they are read, from the advertisement register and the `link_up` input. The reset-request bit of the control register always clears itself.

Top module: `mdio_phy_emu`

## Requirements
- R1: After reset, reads return 0x3100 from register 0, 0x0300 from register 2, 0xE400 from register 3 and 0x01E1 from register 4.
- R2: A write frame stores its 16 data bits in the addressed register. A later read of any register other than 0, 1, 5, 17 and 18 returns that value.
- R3: After every write, bit 15 of register 0 is zero. Writing 0x9140 to register 0 reads back as 0x1140.
- R4: With `link_up` high, register 1 reads 0x782E (bits 14, 13, 12, 11, 5, 3, 2 and 1). With `link_up` low it reads 0x0000. Writes to it do not change what it reads.
- R5: Register 5 reads as 0x4001 OR (register 4 AND 0x01E0).
- R6: Register 17 always reads 0x8000.
- R7: With `link_up` high, register 18 reads bit 10 = reg4[7] OR reg4[8] and bit 11 = reg4[8] OR reg4[6], with all other bits zero. With `link_up` low it reads 0x0000.
- R8: A frame whose PHY address differs from `phy_addr` is ignored. The line is never driven, so a read sees the pull-up value 0xFFFF, and a write leaves the register bank unchanged.
- R9: The opcode is sent MSB first. 10 means read and 01 means write. Any other opcode abandons the frame, so that frame writes nothing and the line is not driven.
- R10: A start pattern (0 then 1) is accepted only after at least 32 consecutive ones. A frame with a shorter preamble has no effect.
- R11: `mdio_oe` is low after reset. It is high only from the second turnaround bit of a matching read to the end of its data phase. The turnaround bit is driven 0, and the 16 data bits follow MSB first. Each bit changes after the management-clock rising edge on which the previous bit was sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the management bus |
| rst_n | input | 1 | Synchronous active-low reset |
| mdc | input | 1 | Management clock from the bus master |
| mdio_i | input | 1 | Management data line as seen at the pad |
| mdio_o | output | 1 | Data value driven during a read response |
| mdio_oe | output | 1 | Output enable for the data line |
| phy_addr | input | 5 | Strap address this PHY answers to |
| link_up | input | 1 | Link state feeding the computed status registers |

## Verification
The bench uses the default parameters: a 32-one preamble, a two-flop input synchroniser and a management clock of sixteen system clocks per bit, with the strap tied to 7. The full preamble length can therefore be tested at its boundary: a 31-one preamble is rejected and a 32-one preamble is accepted. The synchroniser latency also stays well inside half a bit, so each response bit can be sampled just before the next rising edge. The strap value leaves a neighbouring address (3) free to probe the no-response path, and the link input is toggled in mid-run to exercise both forms of the computed status words.

// File: rtl/mdio_phy_pkg.sv
// Package: shared types and constants for the management-bus PHY emulator.
// Assumes 5-bit register numbers and 16-bit register words (clause-22 frame).
package mdio_phy_pkg;

    localparam int REG_AW = 5;
    localparam int REG_DW = 16;
    localparam int NUM_REGS = 1 << REG_AW;

    typedef enum logic [2:0] {
        ST_PRE,
        ST_SOF,
        ST_OPC,
        ST_PADDR,
        ST_RADDR,
        ST_TA,
        ST_DATA
    } mdio_state_e;

    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    // Computed-register numbers
    localparam logic [REG_AW-1:0] RN_CTRL   = 5'd0;
    localparam logic [REG_AW-1:0] RN_STAT   = 5'd1;
    localparam logic [REG_AW-1:0] RN_ADV    = 5'd4;
    localparam logic [REG_AW-1:0] RN_PART   = 5'd5;
    localparam logic [REG_AW-1:0] RN_SPEED  = 5'd17;
    localparam logic [REG_AW-1:0] RN_DIAG   = 5'd18;

    localparam logic [REG_DW-1:0] STAT_LINK_WORD = 16'h782E;
    localparam logic [REG_DW-1:0] PART_FIXED     = 16'h4001;
    localparam logic [REG_DW-1:0] PART_ADV_MASK  = 16'h01E0;
    localparam logic [REG_DW-1:0] SPEED_WORD     = 16'h8000;

    // Reset contents of the stored register bank
    function automatic logic [REG_DW-1:0] init_val(input logic [REG_AW-1:0] idx);
        case (idx)
            5'd0:    return 16'h3100;
            5'd2:    return 16'h0300;
            5'd3:    return 16'hE400;
            5'd4:    return 16'h01E1;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/mdio_in_sync.sv
// Module: mdio_in_sync
// Brings the management clock and data line into the system clock domain and
// flags each management-clock rising edge with the data bit seen with it.
// Assumes the system clock runs several times faster than the management clock
// and that STAGES is at least 2.
module mdio_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc,
    input  logic mdio_i,
    output logic bit_rise,
    output logic bit_val
);

    logic [STAGES-1:0] mdc_sr;
    logic [STAGES-1:0] dio_sr;
    logic              mdc_prev;

    // Shift both bus lines through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_sr   <= '0;
            dio_sr   <= '1;
            mdc_prev <= 1'b0;
        end else begin
            mdc_sr   <= {mdc_sr[STAGES-2:0], mdc};
            dio_sr   <= {dio_sr[STAGES-2:0], mdio_i};
            mdc_prev <= mdc_sr[STAGES-1];
        end
    end

    assign bit_rise = mdc_sr[STAGES-1] & ~mdc_prev;
    assign bit_val  = dio_sr[STAGES-1];

endmodule

// File: rtl/mdio_frame_fsm.sv
// Module: mdio_frame_fsm
// Decodes management frames bit by bit on each management-clock rising edge,
// issues one-cycle write pulses and shifts out read data. Assumes rd_data is
// valid combinationally for rd_addr once the register number is complete.
module mdio_frame_fsm
    import mdio_phy_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_rise,
    input  logic              bit_val,
    input  logic [REG_AW-1:0] strap,
    input  logic [REG_DW-1:0] rd_data,
    output logic [REG_AW-1:0] rd_addr,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_addr,
    output logic [REG_DW-1:0] wr_data,
    output logic              mdio_o,
    output logic              mdio_oe,
    output mdio_state_e       state_o,
    output logic              addr_hit,
    output logic              op_is_rd
);

    localparam int CNT_MAX = (PRE_LEN > REG_DW) ? PRE_LEN : REG_DW;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] C_PRE  = CNT_W'(PRE_LEN);
    localparam logic [CNT_W-1:0] C_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] C_FLD  = CNT_W'(REG_AW - 1);
    localparam logic [CNT_W-1:0] C_DLST = CNT_W'(REG_DW - 1);

    mdio_state_e       state;
    logic [CNT_W-1:0]  cnt;
    logic [1:0]        op;
    logic [REG_AW-1:0] paddr;
    logic [REG_AW-1:0] raddr;
    logic [REG_DW-1:0] shreg;
    logic              oe_q;
    logic              dout_q;
    logic              wr_q;
    logic [REG_DW-1:0] wdat_q;

    assign addr_hit = (paddr == strap);
    assign op_is_rd = (op == OP_RD);

    // Frame decoder: advances one field position per management-clock edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_PRE;
            cnt    <= '0;
            op     <= '0;
            paddr  <= '0;
            raddr  <= '0;
            shreg  <= '0;
            oe_q   <= 1'b0;
            dout_q <= 1'b1;
            wr_q   <= 1'b0;
            wdat_q <= '0;
        end else begin
            wr_q <= 1'b0;
            if (bit_rise) begin
                case (state)
                    ST_PRE: begin
                        if (bit_val) begin
                            if (cnt < C_PRE) cnt <= cnt + C_ONE;
                        end else begin
                            if (cnt == C_PRE) state <= ST_SOF;
                            cnt <= '0;
                        end
                    end
                    ST_SOF: begin
                        state <= bit_val ? ST_OPC : ST_PRE;
                        cnt   <= '0;
                    end
                    ST_OPC: begin
                        op <= {op[0], bit_val};
                        if (cnt == C_ONE) begin
                            cnt   <= '0;
                            state <= ({op[0], bit_val} == OP_RD ||
                                      {op[0], bit_val} == OP_WR) ? ST_PADDR : ST_PRE;
                        end else begin
                            cnt <= cnt + C_ONE;
                        end
                    end
                    ST_PADDR: begin
                        paddr <= {paddr[REG_AW-2:0], bit_val};
                        if (cnt == C_FLD) begin
                            cnt   <= '0;
                            state <= ST_RADDR;
                        end else begin
                            cnt <= cnt + C_ONE;
                        end
                    end
                    ST_RADDR: begin
                        raddr <= {raddr[REG_AW-2:0], bit_val};
                        if (cnt == C_FLD) begin
                            cnt   <= '0;
                            state <= ST_TA;
                        end else begin
                            cnt <= cnt + C_ONE;
                        end
                    end
                    ST_TA: begin
                        if (cnt == '0) begin
                            cnt <= C_ONE;
                            if (op_is_rd && addr_hit) begin
                                oe_q   <= 1'b1;
                                dout_q <= 1'b0;
                                shreg  <= rd_data;
                            end
                        end else begin
                            cnt   <= '0;
                            state <= ST_DATA;
                            if (oe_q) begin
                                dout_q <= shreg[REG_DW-1];
                                shreg  <= {shreg[REG_DW-2:0], 1'b0};
                            end
                        end
                    end
                    ST_DATA: begin
                        if (oe_q) begin
                            if (cnt == C_DLST) begin
                                oe_q   <= 1'b0;
                                dout_q <= 1'b1;
                            end else begin
                                dout_q <= shreg[REG_DW-1];
                                shreg  <= {shreg[REG_DW-2:0], 1'b0};
                            end
                        end else begin
                            shreg <= {shreg[REG_DW-2:0], bit_val};
                        end
                        if (cnt == C_DLST) begin
                            cnt   <= '0;
                            state <= ST_PRE;
                            if (op == OP_WR && addr_hit) begin
                                wr_q   <= 1'b1;
                                wdat_q <= {shreg[REG_DW-2:0], bit_val};
                            end
                        end else begin
                            cnt <= cnt + C_ONE;
                        end
                    end
                    default: begin
                        state <= ST_PRE;
                        cnt   <= '0;
                    end
                endcase
            end
        end
    end

    assign rd_addr = raddr;
    assign wr_addr = raddr;
    assign wr_en   = wr_q;
    assign wr_data = wdat_q;
    assign mdio_o  = dout_q;
    assign mdio_oe = oe_q;
    assign state_o = state;

endmodule

// File: rtl/phy_reg_bank.sv
// Module: phy_reg_bank
// Holds the 32 x 16-bit PHY registers and forms the read word, replacing the
// status, partner, speed and diagnostic registers with live computed values.
// Assumes at most one write per cycle.
module phy_reg_bank
    import mdio_phy_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    input  logic              link_up,
    output logic [REG_DW-1:0] rd_data
);

    logic [REG_DW-1:0] mem [NUM_REGS];
    logic [REG_DW-1:0] adv;

    // Store written words; the control reset bit is cleared on every write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= init_val(REG_AW'(i));
        end else if (wr_en) begin
            mem[wr_addr]  <= wr_data;
            mem[0][15]    <= 1'b0;
        end
    end

    assign adv = mem[RN_ADV];

    // Select the stored word or the computed word for the addressed register
    always_comb begin
        case (rd_addr)
            RN_STAT:  rd_data = link_up ? STAT_LINK_WORD : '0;
            RN_PART:  rd_data = PART_FIXED | (adv & PART_ADV_MASK);
            RN_SPEED: rd_data = SPEED_WORD;
            RN_DIAG:  rd_data = link_up ?
                                {4'b0, adv[8] | adv[6], adv[7] | adv[8], 10'b0} : '0;
            default:  rd_data = mem[rd_addr];
        endcase
    end

endmodule

// File: rtl/mdio_phy_emu.sv
// Module: mdio_phy_emu (top)
// Management-bus slave emulating a simple PHY: synchroniser, frame decoder and
// register bank. Assumes an external pull-up on the data line.
module mdio_phy_emu
    import mdio_phy_pkg::*;
#(
    parameter int PRE_LEN     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mdc,
    input  logic       mdio_i,
    output logic       mdio_o,
    output logic       mdio_oe,
    input  logic [4:0] phy_addr,
    input  logic       link_up
);

    logic              bit_rise;
    logic              bit_val;
    logic [REG_AW-1:0] rd_addr;
    logic [REG_DW-1:0] rd_data;
    logic              wr_en;
    logic [REG_AW-1:0] wr_addr;
    logic [REG_DW-1:0] wr_data;
    mdio_state_e       fsm_state;
    logic              addr_hit;
    logic              op_is_rd;

    mdio_in_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .mdc      (mdc),
        .mdio_i   (mdio_i),
        .bit_rise (bit_rise),
        .bit_val  (bit_val)
    );

    mdio_frame_fsm #(.PRE_LEN(PRE_LEN)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_rise (bit_rise),
        .bit_val  (bit_val),
        .strap    (phy_addr),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .state_o  (fsm_state),
        .addr_hit (addr_hit),
        .op_is_rd (op_is_rd)
    );

    phy_reg_bank i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .link_up (link_up),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/mdio_phy_emu_chk.sv
// Module: mdio_phy_emu_chk
// Protocol and register checks for mdio_phy_emu, attached with bind.
module mdio_phy_emu_chk
    import mdio_phy_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mdio_o,
    input logic              mdio_oe,
    input mdio_state_e       fsm_state,
    input logic              wr_en,
    input logic [REG_AW-1:0] rd_addr,
    input logic [REG_DW-1:0] rd_data,
    input logic              link_up,
    input logic              addr_hit,
    input logic              op_is_rd
);

    a_r11_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> (fsm_state == ST_TA || fsm_state == ST_DATA));

    a_r11_ta_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o);

    a_r8_drive_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> (addr_hit && op_is_rd));

    a_r9_write_needs_op: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (addr_hit && !op_is_rd));

    a_r2_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    a_r3_reset_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == RN_CTRL) |-> !rd_data[15]);

    a_r4_link_down_status: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_up && rd_addr == RN_STAT) |-> (rd_data == '0));

endmodule

bind mdio_phy_emu mdio_phy_emu_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .fsm_state (fsm_state),
    .wr_en     (wr_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .link_up   (link_up),
    .addr_hit  (addr_hit),
    .op_is_rd  (op_is_rd)
);

// File: tb/test_mdio_phy_emu.sv
// Bench: drives management frames as a bus master; a scoreboard queue holds
// expected words, a monitor compares them with words captured from the line.
module test_mdio_phy_emu;

    localparam int HALF_BIT = 8;
    localparam logic [4:0] STRAP = 5'd7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mdc = 1'b0;
    logic m_oe = 1'b0;
    logic m_o = 1'b1;
    logic link_up = 1'b1;
    logic dut_o;
    logic dut_oe;
    logic bus;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] val;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [15:0] got_q[$];

    always #4 clk = ~clk;

    assign bus = m_oe ? m_o : (dut_oe ? dut_o : 1'b1);

    mdio_phy_emu i_mdio_phy_emu (
        .clk      (clk),
        .rst_n    (rst_n),
        .mdc      (mdc),
        .mdio_i   (bus),
        .mdio_o   (dut_o),
        .mdio_oe  (dut_oe),
        .phy_addr (STRAP),
        .link_up  (link_up)
    );

    task automatic one_bit(input logic drv, input logic val, output logic smp);
        @(negedge clk);
        mdc  = 1'b0;
        m_oe = drv;
        m_o  = val;
        repeat (HALF_BIT) @(negedge clk);
        smp = bus;
        mdc = 1'b1;
        repeat (HALF_BIT) @(negedge clk);
    endtask

    task automatic frame(input int pre, input logic [1:0] op, input logic [4:0] pa,
                         input logic [4:0] ra, input logic [15:0] wd, input logic rd_mode,
                         output logic [15:0] rdat, output logic ta2);
        logic s;
        rdat = '0;
        for (int i = 0; i < pre; i++) one_bit(1'b1, 1'b1, s);
        one_bit(1'b1, 1'b0, s);
        one_bit(1'b1, 1'b1, s);
        for (int i = 1; i >= 0; i--) one_bit(1'b1, op[i], s);
        for (int i = 4; i >= 0; i--) one_bit(1'b1, pa[i], s);
        for (int i = 4; i >= 0; i--) one_bit(1'b1, ra[i], s);
        if (rd_mode) begin
            one_bit(1'b0, 1'b1, s);
            one_bit(1'b0, 1'b1, ta2);
            for (int i = 15; i >= 0; i--) begin
                one_bit(1'b0, 1'b1, s);
                rdat[i] = s;
            end
        end else begin
            ta2 = 1'b0;
            one_bit(1'b1, 1'b1, s);
            one_bit(1'b1, 1'b0, s);
            for (int i = 15; i >= 0; i--) one_bit(1'b1, wd[i], s);
        end
        @(negedge clk);
        m_oe = 1'b0;
        mdc  = 1'b0;
    endtask

    // Driver: read frame, pushes expected data word and expected turnaround bit
    task automatic rd_chk(input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] exp_val, input string tag, input logic exp_ta);
        logic [15:0] d;
        logic        t;
        exp_q.push_back('{val: 16'(exp_ta), tag: {tag, " turnaround"}});
        exp_q.push_back('{val: exp_val, tag: tag});
        frame(32, 2'b10, pa, ra, 16'h0, 1'b1, d, t);
        got_q.push_back(16'(t));
        got_q.push_back(d);
    endtask

    task automatic wr(input int pre, input logic [1:0] op, input logic [4:0] pa,
                      input logic [4:0] ra, input logic [15:0] wd);
        logic [15:0] d;
        logic        t;
        frame(pre, op, pa, ra, wd, 1'b0, d, t);
    endtask

    // Monitor: pops captured words and compares with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0 && exp_q.size() > 0) begin
                logic [15:0] g;
                exp_t        e;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                n_checks++;
                if (g !== e.val) begin
                    n_fails++;
                    $display("FAIL %s: got 0x%04h expected 0x%04h", e.tag, g, e.val);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        n_checks++;
        if (dut_oe !== 1'b0) begin
            n_fails++;
            $display("FAIL R11 reset: got oe=%0b expected 0", dut_oe);
        end

        // R1 reset contents
        rd_chk(STRAP, 5'd0, 16'h3100, "R1 reg0", 1'b0);
        rd_chk(STRAP, 5'd2, 16'h0300, "R1 reg2", 1'b0);
        rd_chk(STRAP, 5'd3, 16'hE400, "R1 reg3", 1'b0);
        rd_chk(STRAP, 5'd4, 16'h01E1, "R1 reg4", 1'b0);
        // Computed registers at reset values
        rd_chk(STRAP, 5'd1, 16'h782E, "R4 status link up", 1'b0);
        rd_chk(STRAP, 5'd5, 16'h41E1, "R5 partner default", 1'b0);
        rd_chk(STRAP, 5'd17, 16'h8000, "R6 speed word", 1'b0);
        rd_chk(STRAP, 5'd18, 16'h0C00, "R7 diag default", 1'b0);
        // R2 plain storage
        wr(32, 2'b01, STRAP, 5'd9, 16'hA5C3);
        rd_chk(STRAP, 5'd9, 16'hA5C3, "R2 reg9", 1'b0);
        wr(32, 2'b01, STRAP, 5'd31, 16'h1234);
        rd_chk(STRAP, 5'd31, 16'h1234, "R2 reg31", 1'b0);
        // R3 self-clearing reset bit
        wr(32, 2'b01, STRAP, 5'd0, 16'h9140);
        rd_chk(STRAP, 5'd0, 16'h1140, "R3 reg0", 1'b0);
        // R5/R7 follow the advertisement register
        wr(32, 2'b01, STRAP, 5'd4, 16'h0040);
        rd_chk(STRAP, 5'd18, 16'h0800, "R7 diag 10 full", 1'b0);
        rd_chk(STRAP, 5'd5, 16'h4041, "R5 partner 10 full", 1'b0);
        wr(32, 2'b01, STRAP, 5'd4, 16'h0080);
        rd_chk(STRAP, 5'd18, 16'h0400, "R7 diag 100 half", 1'b0);
        wr(32, 2'b01, STRAP, 5'd4, 16'h0100);
        rd_chk(STRAP, 5'd18, 16'h0C00, "R7 diag 100 full", 1'b0);
        // R4 writes to status do not stick
        wr(32, 2'b01, STRAP, 5'd1, 16'h0000);
        rd_chk(STRAP, 5'd1, 16'h782E, "R4 status after write", 1'b0);
        // Link down
        link_up = 1'b0;
        rd_chk(STRAP, 5'd1, 16'h0000, "R4 status link down", 1'b0);
        rd_chk(STRAP, 5'd18, 16'h0000, "R7 diag link down", 1'b0);
        link_up = 1'b1;
        rd_chk(STRAP, 5'd1, 16'h782E, "R4 status link back", 1'b0);
        // R8 other address
        rd_chk(5'd3, 5'd9, 16'hFFFF, "R8 foreign read", 1'b1);
        wr(32, 2'b01, 5'd3, 5'd9, 16'h0000);
        rd_chk(STRAP, 5'd9, 16'hA5C3, "R8 foreign write ignored", 1'b0);
        // R9 invalid opcodes
        wr(32, 2'b11, STRAP, 5'd9, 16'h1111);
        rd_chk(STRAP, 5'd9, 16'hA5C3, "R9 opcode 11 ignored", 1'b0);
        wr(32, 2'b00, STRAP, 5'd9, 16'h3333);
        rd_chk(STRAP, 5'd9, 16'hA5C3, "R9 opcode 00 ignored", 1'b0);
        // R10 short preamble
        wr(31, 2'b01, STRAP, 5'd9, 16'h2222);
        rd_chk(STRAP, 5'd9, 16'hA5C3, "R10 short preamble ignored", 1'b0);
        wr(32, 2'b01, STRAP, 5'd9, 16'h2222);
        rd_chk(STRAP, 5'd9, 16'h2222, "R10 full preamble accepted", 1'b0);

        repeat (20) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_checks++;
            n_fails++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule